// File: doc/BRIEF.md
# Two-Frame Receive Elastic Store

This block sits in a receive path between a recovered line clock and an unrelated backplane clock. Framed timeslot bytes enter on the line side. A frame marker flags the first byte of each line frame. The bytes leave on the backplane side, aligned to a system frame pulse. The buffer holds two complete frames. The block compares frame counters once per output frame, at the system frame pulse. When the two sides drift apart, the block repeats or discards a whole frame. The frame structure at the backplane is never broken.

The frame pointers cross clock domains in a defined way. The line side publishes its frame counter as a 2-bit Gray code. The backplane side takes it through a two-flop synchronizer. A line frame counts as complete once the next line frame marker has arrived. After reset, or after the buffer is enabled, the read counter sits one frame behind the first frame to be written, so the buffer starts half full.

In E1 mode with a 1.544 MHz backplane, the block maps the E1 stream onto a 24-channel output frame. A 32-bit mask removes eight E1 channels. A framing-bit slot is inserted ahead of the remaining channels. A per-channel blocking output and a multiframe marker are also provided. The multiframe marker follows one of two line-side multiframe tags. Latched slip, empty and full flags drive a masked interrupt. A bypass setting passes line data straight to the output.

Top module: `frame_elastic_buf`

## Requirements
- R1: After reset `sts` is 000, `irq` is 0, and `rd_data`, `rd_fbit`, `rd_chblk` and `rd_mfs` are all 0.
- R2: At a steady rate, each output frame carries a single line frame in channel order. Successive output frames carry successive line frames. No flag is set.
- R3: At an output frame pulse, the next line frame may not yet be complete (the next line frame marker has not been seen). The block then outputs the previous frame again. It sets sts bit 0 (slip) and bit 1 (empty).
- R4: At an output frame pulse, the writer may have started a second frame beyond the one being read. The block then skips one whole frame. It sets sts bit 0 (slip) and bit 2 (full).
- R5: Each sts bit stays set until a 1 is written to the matching `sts_clr` bit for one cycle. `irq` is the OR over the three bits of `sts & sts_mask`.
- R6: With `e1_mode`=1 and `bp_t1`=1, the first output slot of each frame is a framing slot. In that slot `rd_fbit` is 1 and `rd_data` is 0. The next 24 slots carry, in ascending order, the E1 channels whose `drop_mask` bit is 0.
- R7: `rd_chblk` equals `blk_mask[k]` for output channel k, where output channel 0 is the first data slot. In the 24-channel mapping, bits 24 to 31 of `blk_mask` never appear on `rd_chblk`, and the framing slot is never blocked.
- R8: In E1 mode, `rd_mfs` is 1 in the first slot of an output frame only when that frame was written with the selected tag: `wr_crc_mf` when `mfs_crc`=1, otherwise `wr_cas_mf`.
- R9: With `es_en`=0, `rd_data` follows `wr_data` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Line-side clock |
| wrst_n | input | 1 | Line-side asynchronous active-low reset |
| wr_en | input | 1 | Line byte strobe |
| wr_fs | input | 1 | Line frame marker, on the first byte of a frame |
| wr_data | input | DW | Line timeslot byte |
| wr_cas_mf | input | 1 | Tag: this frame starts a signaling multiframe (sampled with wr_fs) |
| wr_crc_mf | input | 1 | Tag: this frame starts a check multiframe (sampled with wr_fs) |
| rclk | input | 1 | Backplane clock |
| rrst_n | input | 1 | Backplane asynchronous active-low reset |
| rd_en | input | 1 | Backplane slot strobe |
| rd_fs | input | 1 | System frame pulse, on the first slot |
| rd_data | output | DW | Output byte, registered; in bypass, wr_data |
| rd_fbit | output | 1 | Framing-bit slot indicator (value 1) |
| rd_chblk | output | 1 | Channel blocking output |
| rd_mfs | output | 1 | Multiframe boundary marker |
| es_en | input | 1 | 1 enables the buffer, 0 bypasses it |
| e1_mode | input | 1 | 1 for E1 line data |
| bp_t1 | input | 1 | 1 selects the 24-channel backplane mapping (with e1_mode) |
| mfs_crc | input | 1 | Multiframe tag select |
| drop_mask | input | NCH | 1 removes that E1 channel in the mapping |
| blk_mask | input | NCH | Per output channel blocking bits |
| sts_clr | input | 3 | Write-one-to-clear pulses for sts |
| sts_mask | input | 3 | Interrupt enables for sts |
| sts | output | 3 | Latched flags: bit 0 slip, bit 1 empty, bit 2 full |
| irq | output | 1 | Masked interrupt |

## Verification
The bench stalls the line side for one frame time to force a repeat. A design that advanced anyway would output a half-written frame, or would skip the repeat and leave the empty flag clear. It stalls the backplane side for one frame time to force a deletion. A design that stepped only one frame would read the slot the writer is filling, and each frame's bytes would then mix two line frames. In the 24-channel mapping it checks, slot by slot, the framing slot, the order of the kept channels and the blocking bits. An off-by-one search or a blocking index that ignores the framing slot would show up on every frame. It also checks the sticky flags, clears them one bit at a time, and checks the interrupt under two different masks.

// File: rtl/es_pkg.sv
package es_pkg;
  localparam int FLG_SLIP  = 0;
  localparam int FLG_EMPTY = 1;
  localparam int FLG_FULL  = 2;
  localparam int NFLG      = 3;

  function automatic logic [1:0] bin2gray(input logic [1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [1:0] gray2bin(input logic [1:0] g);
    return {g[1], g[1] ^ g[0]};
  endfunction
endpackage

// File: rtl/es_wr_side.sv
module es_wr_side #(
  parameter int NCH = 32,
  parameter int DW  = 8
) (
  input  logic                      wclk,
  input  logic                      wrst_n,
  input  logic                      es_en,
  input  logic                      wr_en,
  input  logic                      wr_fs,
  input  logic [DW-1:0]             wr_data,
  input  logic                      wr_cas_mf,
  input  logic                      wr_crc_mf,
  output logic [1:0]                wgray,
  input  logic [$clog2(NCH):0]      rd_addr,
  output logic [DW-1:0]             rd_word,
  input  logic                      tag_slot,
  output logic [1:0]                tag_word
);
  import es_pkg::*;
  localparam int CW  = $clog2(NCH);
  localparam int CHW = CW + 1;

  logic [DW-1:0] mem [2*NCH];
  logic [1:0]    tag [2];
  logic [1:0]    wcnt, wcnt_n;
  logic [CHW-1:0] wch, wch_n;
  logic [CW-1:0] wa_ch;
  logic          we;

  always_comb begin
    wcnt_n = wcnt;
    wch_n  = wch;
    wa_ch  = wch[CW-1:0];
    we     = 1'b0;
    if (!es_en) begin
      wcnt_n = '0;
      wch_n  = '0;
    end else if (wr_en) begin
      if (wr_fs) begin
        wcnt_n = wcnt + 2'd1;
        wch_n  = CHW'(1);
        wa_ch  = '0;
        we     = 1'b1;
      end else if (wch < CHW'(NCH)) begin
        wch_n  = wch + CHW'(1);
        we     = 1'b1;
      end
    end
  end

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wcnt  <= '0;
      wch   <= '0;
      wgray <= '0;
    end else begin
      wcnt  <= wcnt_n;
      wch   <= wch_n;
      wgray <= bin2gray(wcnt_n);
    end
  end

  always_ff @(posedge wclk) begin
    if (we) mem[{wcnt_n[0], wa_ch}] <= wr_data;
    if (we && wr_fs) tag[wcnt_n[0]] <= {wr_crc_mf, wr_cas_mf};
  end

  assign rd_word  = mem[rd_addr];
  assign tag_word = tag[tag_slot];

  // R2
  wr_first_chk: assert property (@(posedge wclk) disable iff (!wrst_n)
    (es_en && wr_en && wr_fs) |=> (wch == CHW'(1)));
endmodule

// File: rtl/es_gray_sync.sv
module es_gray_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0;
      q  <= '0;
    end else begin
      s1 <= d;
      q  <= s1;
    end
  end
endmodule

// File: rtl/es_rd_side.sv
module es_rd_side #(
  parameter int NCH   = 32,
  parameter int DW    = 8,
  parameter int MAPCH = 24
) (
  input  logic                 rclk,
  input  logic                 rrst_n,
  input  logic                 es_en,
  input  logic                 rd_en,
  input  logic                 rd_fs,
  input  logic                 e1_mode,
  input  logic                 bp_t1,
  input  logic                 mfs_crc,
  input  logic [NCH-1:0]       drop_mask,
  input  logic [NCH-1:0]       blk_mask,
  input  logic [1:0]           wbin,
  output logic [$clog2(NCH):0] mem_addr,
  input  logic [DW-1:0]        mem_word,
  output logic                 tag_slot,
  input  logic [1:0]           tag_word,
  output logic [DW-1:0]        rd_data_q,
  output logic                 rd_fbit_q,
  output logic                 rd_chblk_q,
  output logic                 rd_mfs_q,
  output logic                 ev_uf,
  output logic                 ev_of
);
  localparam int CW  = $clog2(NCH);
  localparam int CHW = CW + 1;

  function automatic logic [CHW-1:0] first_keep(input logic [NCH-1:0] m,
                                                input logic [CHW-1:0] from);
    logic [CHW-1:0] r;
    r = CHW'(NCH);
    for (int i = NCH - 1; i >= 0; i--)
      if (i >= int'(from) && !m[i]) r = CHW'(i);
    return r;
  endfunction

  logic [1:0]     rcnt, rcnt_n, fsel, diff;
  logic [CHW-1:0] rch, rch_n, oslot, oslot_n, ch_rd, blk_idx;
  logic           map, fs_go, fslot, upd;
  logic [DW-1:0]  data_n;
  logic           chblk_n, mfs_n;

  always_comb begin
    map     = e1_mode && bp_t1;
    fs_go   = es_en && rd_en && rd_fs;
    upd     = es_en && rd_en;
    diff    = wbin - rcnt;
    ev_uf   = fs_go && (diff == 2'd0 || diff == 2'd1);
    ev_of   = fs_go && (diff == 2'd3);
    fsel    = rcnt;
    if (ev_of)      fsel = rcnt + 2'd2;
    else if (fs_go && !ev_uf) fsel = rcnt + 2'd1;
    rcnt_n  = es_en ? fsel : 2'd0;
    rch_n   = rch;
    oslot_n = oslot;
    ch_rd   = rch;
    blk_idx = oslot;
    fslot   = 1'b0;
    if (fs_go) begin
      blk_idx = '0;
      if (map) begin
        fslot   = 1'b1;
        rch_n   = first_keep(drop_mask, '0);
        oslot_n = '0;
      end else begin
        ch_rd   = '0;
        rch_n   = CHW'(1);
        oslot_n = CHW'(1);
      end
    end else if (upd) begin
      if (rch < CHW'(NCH))
        rch_n = map ? first_keep(drop_mask, rch + CHW'(1)) : rch + CHW'(1);
      if (oslot < CHW'(NCH)) oslot_n = oslot + CHW'(1);
    end
    mem_addr = {fsel[0], ch_rd[CW-1:0]};
    tag_slot = fsel[0];
    data_n   = (fslot || ch_rd >= CHW'(NCH)) ? '0 : mem_word;
    chblk_n  = !fslot && (blk_idx < CHW'(NCH)) && blk_mask[blk_idx[CW-1:0]]
               && !(map && blk_idx >= CHW'(MAPCH));
    mfs_n    = fs_go && e1_mode && (mfs_crc ? tag_word[1] : tag_word[0]);
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rcnt       <= '0;
      rch        <= '0;
      oslot      <= '0;
      rd_data_q  <= '0;
      rd_fbit_q  <= 1'b0;
      rd_chblk_q <= 1'b0;
      rd_mfs_q   <= 1'b0;
    end else begin
      rcnt <= rcnt_n;
      if (upd) begin
        rch        <= rch_n;
        oslot      <= oslot_n;
        rd_data_q  <= data_n;
        rd_fbit_q  <= fslot;
        rd_chblk_q <= chblk_n;
        rd_mfs_q   <= mfs_n;
      end
    end
  end

  // R3
  uf_repeat_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
    ev_uf |=> (rcnt == $past(rcnt)));
  // R4
  of_skip_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
    ev_of |=> (rcnt == $past(rcnt) + 2'd2));
  // R6
  fbit_slot_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
    rd_fbit_q |-> (rd_data_q == '0 && !rd_chblk_q));
  // R7
  map_blk_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
    (upd && map && !fs_go) |=> (!rd_chblk_q || $past(oslot) < CHW'(MAPCH)));
endmodule

// File: rtl/es_status.sv
module es_status (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [es_pkg::NFLG-1:0]  set,
  input  logic [es_pkg::NFLG-1:0]  clr,
  input  logic [es_pkg::NFLG-1:0]  mask,
  output logic [es_pkg::NFLG-1:0]  flags,
  output logic                     irq
);
  import es_pkg::*;
  logic [NFLG-1:0] flags_n;

  always_comb flags_n = (flags & ~clr) | set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= flags_n;
  end

  assign irq = |(flags & mask);

  // R5
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags & $past(flags & ~clr)) == $past(flags & ~clr)));
  // R5
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags & $past(set)) == $past(set)));
endmodule

// File: rtl/frame_elastic_buf.sv
module frame_elastic_buf #(
  parameter int NCH   = 32,
  parameter int DW    = 8,
  parameter int MAPCH = 24
) (
  input  logic           wclk,
  input  logic           wrst_n,
  input  logic           wr_en,
  input  logic           wr_fs,
  input  logic [DW-1:0]  wr_data,
  input  logic           wr_cas_mf,
  input  logic           wr_crc_mf,
  input  logic           rclk,
  input  logic           rrst_n,
  input  logic           rd_en,
  input  logic           rd_fs,
  output logic [DW-1:0]  rd_data,
  output logic           rd_fbit,
  output logic           rd_chblk,
  output logic           rd_mfs,
  input  logic           es_en,
  input  logic           e1_mode,
  input  logic           bp_t1,
  input  logic           mfs_crc,
  input  logic [NCH-1:0] drop_mask,
  input  logic [NCH-1:0] blk_mask,
  input  logic [2:0]     sts_clr,
  input  logic [2:0]     sts_mask,
  output logic [2:0]     sts,
  output logic           irq
);
  import es_pkg::*;
  localparam int AW = $clog2(NCH) + 1;

  logic [1:0]    wgray, wgray_s;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_word, rd_data_q;
  logic          tag_slot, ev_uf, ev_of;
  logic [1:0]    tag_word;
  logic [NFLG-1:0] set;

  es_wr_side #(.NCH(NCH), .DW(DW)) u_wr (
    .wclk(wclk), .wrst_n(wrst_n), .es_en(es_en), .wr_en(wr_en), .wr_fs(wr_fs),
    .wr_data(wr_data), .wr_cas_mf(wr_cas_mf), .wr_crc_mf(wr_crc_mf),
    .wgray(wgray), .rd_addr(mem_addr), .rd_word(mem_word),
    .tag_slot(tag_slot), .tag_word(tag_word));

  es_gray_sync #(.W(2)) u_sync (
    .clk(rclk), .rst_n(rrst_n), .d(wgray), .q(wgray_s));

  es_rd_side #(.NCH(NCH), .DW(DW), .MAPCH(MAPCH)) u_rd (
    .rclk(rclk), .rrst_n(rrst_n), .es_en(es_en), .rd_en(rd_en), .rd_fs(rd_fs),
    .e1_mode(e1_mode), .bp_t1(bp_t1), .mfs_crc(mfs_crc),
    .drop_mask(drop_mask), .blk_mask(blk_mask), .wbin(gray2bin(wgray_s)),
    .mem_addr(mem_addr), .mem_word(mem_word), .tag_slot(tag_slot),
    .tag_word(tag_word), .rd_data_q(rd_data_q), .rd_fbit_q(rd_fbit),
    .rd_chblk_q(rd_chblk), .rd_mfs_q(rd_mfs), .ev_uf(ev_uf), .ev_of(ev_of));

  always_comb begin
    set            = '0;
    set[FLG_SLIP]  = ev_uf | ev_of;
    set[FLG_EMPTY] = ev_uf;
    set[FLG_FULL]  = ev_of;
  end

  es_status u_sts (
    .clk(rclk), .rst_n(rrst_n), .set(set), .clr(sts_clr), .mask(sts_mask),
    .flags(sts), .irq(irq));

  assign rd_data = es_en ? rd_data_q : wr_data;

  // R9
  bypass_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
    !es_en |-> (rd_data == wr_data));
endmodule

// File: tb/frame_elastic_buf_tb_top.sv
module frame_elastic_buf_tb_top;
  logic clk = 1'b0;
  logic rst_n;
  logic wr_en, wr_fs, wr_cas_mf, wr_crc_mf, rd_en, rd_fs;
  logic [7:0] wr_data, rd_data;
  logic rd_fbit, rd_chblk, rd_mfs, irq;
  logic es_en, e1_mode, bp_t1, mfs_crc;
  logic [31:0] drop_mask, blk_mask;
  logic [2:0] sts_clr, sts_mask, sts;

  always #4 clk = ~clk;

  frame_elastic_buf dut_i (
    .wclk(clk), .wrst_n(rst_n), .wr_en(wr_en), .wr_fs(wr_fs), .wr_data(wr_data),
    .wr_cas_mf(wr_cas_mf), .wr_crc_mf(wr_crc_mf),
    .rclk(clk), .rrst_n(rst_n), .rd_en(rd_en), .rd_fs(rd_fs),
    .rd_data(rd_data), .rd_fbit(rd_fbit), .rd_chblk(rd_chblk), .rd_mfs(rd_mfs),
    .es_en(es_en), .e1_mode(e1_mode), .bp_t1(bp_t1), .mfs_crc(mfs_crc),
    .drop_mask(drop_mask), .blk_mask(blk_mask), .sts_clr(sts_clr),
    .sts_mask(sts_mask), .sts(sts), .irq(irq));

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  int w_ch = 0, w_fid = 1, r_pos = 0;
  int rx_n = 0;
  int rx_fid [0:255];
  int cur_fid = 0, bad = 0;
  bit pend_mfs = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit map_on();
    return e1_mode && bp_t1;
  endfunction

  function automatic int exp_ch(input int j);
    int c = 0;
    if (!map_on()) return j;
    for (int i = 0; i < 32; i++)
      if (!drop_mask[i]) begin
        if (c == j) return i;
        c++;
      end
    return 99;
  endfunction

  task automatic capture(input int slot);
    int nd, j;
    bit m, em;
    nd = map_on() ? 24 : 32;
    if (map_on() && slot == 0) begin
      chk(rd_fbit == 1'b1 && rd_data == 8'd0 && !rd_chblk, "R6",
          "framing slot fbit/data", int'(rd_data), 0);
      pend_mfs = rd_mfs;
      return;
    end
    j = map_on() ? slot - 1 : slot;
    if (j == 0) begin
      cur_fid = int'(rd_data[7:5]);
      rx_fid[rx_n % 256] = cur_fid;
      rx_n++;
      bad = 0;
      m  = map_on() ? pend_mfs : rd_mfs;
      em = e1_mode && (mfs_crc ? (cur_fid % 4 == 2) : (cur_fid % 4 == 0));
      chk(m == em, "R8", "multiframe marker", int'(m), int'(em));
    end
    if (int'(rd_data[4:0]) != exp_ch(j) || int'(rd_data[7:5]) != cur_fid) bad++;
    if (rd_fbit) bad++;
    if (rd_chblk != blk_mask[j]) bad++;
    if (j == nd - 1)
      chk(bad == 0, map_on() ? "R6" : "R2", "frame content/blocking (R7) errors",
          bad, 0);
  endtask

  task automatic cyc(input bit w, input bit r);
    int rlen, slot;
    bit did;
    rlen = map_on() ? 25 : 32;
    wr_en     = w;
    wr_fs     = w && (w_ch == 0);
    wr_data   = 8'((w_fid % 8) * 32 + w_ch);
    wr_cas_mf = (w_fid % 4 == 0);
    wr_crc_mf = (w_fid % 4 == 2);
    did   = r && (r_pos < rlen);
    rd_en = did;
    rd_fs = did && (r_pos == 0);
    slot  = r_pos;
    @(posedge clk);
    @(negedge clk);
    if (did) capture(slot);
    if (w) begin
      w_ch++;
      if (w_ch == 32) begin w_ch = 0; w_fid++; end
    end
    if (r) r_pos = (r_pos + 1) % 32;
  endtask

  task automatic run(input int n, input bit w, input bit r);
    for (int i = 0; i < n; i++) cyc(w, r);
  endtask

  task automatic t_reset();
    chk(sts == 3'b000 && !irq, "R1", "flags/irq after reset", int'(sts), 0);
    chk(rd_data == 8'd0 && !rd_fbit && !rd_chblk && !rd_mfs, "R1",
        "outputs after reset", int'(rd_data), 0);
  endtask

  task automatic t_normal();
    int base;
    run(48, 1'b1, 1'b0);
    base = rx_n;
    run(128, 1'b1, 1'b1);
    chk(rx_n - base == 4, "R2", "frames read", rx_n - base, 4);
    for (int k = 0; k < 4; k++)
      chk(rx_fid[(base + k) % 256] == (k + 1) % 8, "R2", "frame order",
          rx_fid[(base + k) % 256], (k + 1) % 8);
    chk(sts == 3'b000, "R2", "no flag in steady state", int'(sts), 0);
  endtask

  task automatic t_underflow();
    int base, prev;
    base = rx_n;
    prev = rx_fid[(rx_n - 1) % 256];
    run(32, 1'b0, 1'b1);
    run(64, 1'b1, 1'b1);
    chk(rx_fid[base % 256] == (prev + 1) % 8, "R3", "frame before repeat",
        rx_fid[base % 256], (prev + 1) % 8);
    chk(rx_fid[(base + 1) % 256] == (prev + 1) % 8, "R3", "repeated frame",
        rx_fid[(base + 1) % 256], (prev + 1) % 8);
    chk(rx_fid[(base + 2) % 256] == (prev + 2) % 8, "R3", "frame after repeat",
        rx_fid[(base + 2) % 256], (prev + 2) % 8);
    chk(sts == 3'b011, "R3", "slip+empty flags", int'(sts), 3);
    sts_mask = 3'b010;
    #1;
    chk(irq == 1'b1, "R5", "irq with empty enabled", int'(irq), 1);
    sts_mask = 3'b100;
    #1;
    chk(irq == 1'b0, "R5", "irq with only full enabled", int'(irq), 0);
    sts_clr = 3'b010;
    cyc(1'b1, 1'b1);
    sts_clr = 3'b000;
    chk(sts == 3'b001, "R5", "clear of empty bit only", int'(sts), 1);
    run(15, 1'b1, 1'b1);
    chk(sts == 3'b001, "R5", "slip bit stays set", int'(sts), 1);
    sts_clr = 3'b111;
    cyc(1'b1, 1'b1);
    sts_clr = 3'b000;
    chk(sts == 3'b000, "R5", "clear all", int'(sts), 0);
    run(15, 1'b1, 1'b1);
  endtask

  task automatic t_overflow();
    int base, prev;
    base = rx_n;
    prev = rx_fid[(rx_n - 1) % 256];
    run(32, 1'b1, 1'b0);
    run(64, 1'b1, 1'b1);
    chk(rx_fid[base % 256] == (prev + 2) % 8, "R4", "frame after deletion",
        rx_fid[base % 256], (prev + 2) % 8);
    chk(rx_fid[(base + 1) % 256] == (prev + 3) % 8, "R4", "next frame",
        rx_fid[(base + 1) % 256], (prev + 3) % 8);
    chk(sts == 3'b101, "R4", "slip+full flags", int'(sts), 5);
    #1;
    chk(irq == 1'b1, "R5", "irq with full enabled", int'(irq), 1);
    sts_clr = 3'b111;
    cyc(1'b1, 1'b1);
    sts_clr = 3'b000;
    run(31, 1'b1, 1'b1);
    chk(sts == 3'b000 && !irq, "R5", "cleared after deletion", int'(sts), 0);
  endtask

  task automatic t_map();
    int base;
    bp_t1     = 1'b1;
    mfs_crc   = 1'b1;
    drop_mask = 32'hF101_0101;
    blk_mask  = 32'hFF00_0003;
    base = rx_n;
    run(128, 1'b1, 1'b1);
    chk(rx_n - base == 4, "R6", "mapped frames read", rx_n - base, 4);
    for (int k = 1; k < 4; k++)
      chk(rx_fid[(base + k) % 256] == (rx_fid[base % 256] + k) % 8, "R7",
          "mapped frame order", rx_fid[(base + k) % 256],
          (rx_fid[base % 256] + k) % 8);
    chk(sts == 3'b000, "R6", "no slip in mapping", int'(sts), 0);
  endtask

  task automatic t_bypass();
    es_en   = 1'b0;
    wr_en   = 1'b0;
    wr_data = 8'h3C;
    #1;
    chk(rd_data == 8'h3C, "R9", "bypass data", int'(rd_data), 8'h3C);
    wr_data = 8'hC3;
    #1;
    chk(rd_data == 8'hC3, "R9", "bypass data follows", int'(rd_data), 8'hC3);
  endtask

  initial begin
    rst_n = 1'b0;
    wr_en = 1'b0; wr_fs = 1'b0; wr_data = '0; wr_cas_mf = 1'b0; wr_crc_mf = 1'b0;
    rd_en = 1'b0; rd_fs = 1'b0;
    es_en = 1'b1; e1_mode = 1'b1; bp_t1 = 1'b0; mfs_crc = 1'b0;
    drop_mask = '0; blk_mask = 32'h8000_0005;
    sts_clr = '0; sts_mask = 3'b000;
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_normal();
    t_underflow();
    t_overflow();
    t_map();
    t_bypass();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual 0 expected 1 (run did not complete)");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule